// File: doc/BRIEF.md
# CAN Transmit Buffer Lifecycle Controller

This block keeps the code field of a small set of CAN transmit message buffers and moves each buffer through its life. Software arms a buffer, the protocol engine starts and completes the frame, and the block records the outcome. Arbitration, payload storage and the bus protocol are handled elsewhere. On a completed frame the block latches the free-running timer as the buffer's time stamp, returns the code to inactive and raises the buffer's flag. The shared interrupt line follows the flags that are enabled by the mask.

Software may abort a buffer that has been armed, and the `abort_en` level selects how. When `abort_en` is high, the abort is a handshake with the engine. An abort that arrives before the frame starts withdraws the buffer and reports this through the flag. An abort that arrives once the frame is on the bus is refused, and the frame completes normally. When `abort_en` is low, the older deactivation applies. Writing the inactive code takes the buffer out of use with no flag, and a frame that had already started still goes out silently.

All pins are plain control and status pins, with one-cycle strobes and combinational read-back. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `can_txbuf_lifecycle`

## Requirements
- R1: After reset every buffer reads code 4'b1000 (inactive), with a time stamp of 0. All flags and `irq` are 0.
- R2: A write of 4'b1100 (transmit data) to an idle buffer that reads 4'b1000 or 4'b1001 arms it, and the read-back becomes 4'b1100 on the next cycle. A write of any code other than 4'b1000, 4'b1001 or 4'b1100 is ignored.
- R3: `eng_start` naming an armed buffer starts its transmission. `eng_start` or `eng_done` naming a buffer that is not armed, or not transmitting, has no effect.
- R4: `eng_done` for a transmitting buffer that still reads 4'b1100 has three effects on the next cycle. The code becomes 4'b1000, the flag is set, and the time stamp equals the `timer_val` sampled in the done cycle.
- R5: `irq` is high exactly when some flag is set whose `irq_mask` bit is also set.
- R6: Flags are write-1-to-clear through `cpu_clr_en` and `cpu_clr_bits`. A 0 bit leaves its flag unchanged. A flag set in the same cycle as its clear stays set.
- R7: With `abort_en` high, a write of 4'b1001 to an armed buffer that has not started makes the code 4'b1001 and sets the flag. The time stamp is unchanged, and later engine strobes for that buffer are ignored.
- R8: With `abort_en` high, a write of 4'b1001 to a buffer that is transmitting, or that starts in the same cycle, is ignored. The buffer keeps reading 4'b1100 and completes as in R4.
- R9: With `abort_en` low, a write of 4'b1000 to an armed buffer makes it read 4'b1000 without setting the flag. If the buffer was transmitting, the later `eng_done` sets no flag and leaves the time stamp unchanged.
- R10: With `abort_en` low, a write of 4'b1001 to an armed buffer is ignored. With `abort_en` high, a write of 4'b1000 to an armed buffer is ignored.
- R11: While a silently deactivated frame is still transmitting, a write of 4'b1100 is ignored. When a CPU write and `eng_done` reach the same buffer in one cycle, completion takes precedence and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_en | input | 1 | 1: abort as a handshake with notification; 0: silent deactivation |
| cpu_wr_en | input | 1 | Code-field write strobe |
| cpu_wr_idx | input | IDX_W | Buffer written |
| cpu_wr_code | input | 4 | Code value written |
| cpu_clr_en | input | 1 | Flag clear strobe |
| cpu_clr_bits | input | NUM_MB | Write-1-to-clear flag bits |
| cpu_rd_idx | input | IDX_W | Buffer read back |
| cpu_rd_code | output | 4 | Code of the selected buffer |
| cpu_rd_stamp | output | TS_W | Time stamp of the selected buffer |
| eng_start | input | 1 | Engine began sending a buffer |
| eng_start_idx | input | IDX_W | Buffer being started |
| eng_done | input | 1 | Engine finished sending a buffer successfully |
| eng_done_idx | input | IDX_W | Buffer finished |
| timer_val | input | TS_W | Free-running timer |
| irq_mask | input | NUM_MB | Per-buffer interrupt enable |
| flags | output | NUM_MB | Per-buffer completion/abort flags |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of event can collide in one cycle: a software abort and the engine's start strobe for the same buffer. The bench drives the 4'b1001 write and `eng_start` on the same clock edge, checks that the buffer still reads 4'b1100 with no flag, then ends the frame and expects a normal completion. It also lands a flag clear on the cycle of `eng_done`, and a legacy deactivation write on the cycle of `eng_done`. Each outcome is judged from the read-back code, flag and time stamp one cycle later.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;

  typedef enum logic [3:0] {
    CODE_INACTIVE = 4'b1000,
    CODE_ABORTED  = 4'b1001,
    CODE_TXDATA   = 4'b1100
  } txb_code_e;

endpackage

// File: rtl/can_txbuf_dec.sv
module can_txbuf_dec #(
  parameter int NUM_MB = 4,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             done,
  input  logic [IDX_W-1:0] done_idx,
  output logic [NUM_MB-1:0] wr_sel,
  output logic [NUM_MB-1:0] start_sel,
  output logic [NUM_MB-1:0] done_sel
);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_sel
    assign wr_sel[g]    = wr_en && (wr_idx == IDX_W'(g));
    assign start_sel[g] = start && (start_idx == IDX_W'(g));
    assign done_sel[g]  = done && (done_idx == IDX_W'(g));
  end

endmodule

// File: rtl/can_txbuf_slot.sv
module can_txbuf_slot
  import can_txbuf_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort_en,
  input  logic            wr_i,
  input  logic [3:0]      wr_code_i,
  input  logic            start_i,
  input  logic            done_i,
  input  logic            clr_i,
  input  logic [TS_W-1:0] timer_i,
  output logic [3:0]      code_o,
  output logic            flag_o,
  output logic [TS_W-1:0] stamp_o
);

  txb_code_e       code_q, code_d;
  logic            busy_q, busy_d;
  logic            flag_q, flag_d;
  logic [TS_W-1:0] stamp_q;

  logic pending, start_ok, done_ok, notify;
  logic abort_ok, legacy_off, idle_deact, activate;

  always_comb begin
    pending    = (code_q == CODE_TXDATA);
    start_ok   = start_i && pending && !busy_q;
    done_ok    = done_i && busy_q;
    notify     = done_ok && pending;
    abort_ok   = wr_i && abort_en && pending && !busy_q && !start_i &&
                 (wr_code_i == CODE_ABORTED);
    legacy_off = wr_i && !abort_en && pending && (wr_code_i == CODE_INACTIVE);
    idle_deact = wr_i && (code_q == CODE_ABORTED) && !busy_q &&
                 (wr_code_i == CODE_INACTIVE);
    activate   = wr_i && !pending && !busy_q && (wr_code_i == CODE_TXDATA);
  end

  always_comb begin
    code_d = code_q;
    if (notify)                       code_d = CODE_INACTIVE;
    else if (abort_ok)                code_d = CODE_ABORTED;
    else if (legacy_off || idle_deact) code_d = CODE_INACTIVE;
    else if (activate)                code_d = CODE_TXDATA;

    busy_d = busy_q;
    if (done_ok)       busy_d = 1'b0;
    else if (start_ok) busy_d = 1'b1;

    flag_d = flag_q;
    if (notify || abort_ok) flag_d = 1'b1;
    else if (clr_i)         flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_INACTIVE;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      stamp_q <= '0;
    end else begin
      code_q <= code_d;
      busy_q <= busy_d;
      flag_q <= flag_d;
      if (notify) stamp_q <= timer_i;
    end
  end

  assign code_o  = code_q;
  assign flag_o  = flag_q;
  assign stamp_o = stamp_q;

  // R4
  done_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q && code_q == CODE_TXDATA) |=>
      (code_q == CODE_INACTIVE && flag_q && stamp_q == $past(timer_i)));

  // R7
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_q == CODE_ABORTED) |-> (flag_q && $past(abort_en) && !$past(busy_q)));

  // R8
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && abort_en && busy_q && code_q == CODE_TXDATA && !done_i &&
     wr_code_i == CODE_ABORTED) |=> (code_q == CODE_TXDATA));

  // R9
  silent_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q && code_q == CODE_INACTIVE && !clr_i) |=>
      ($stable(flag_q) && $stable(stamp_q)));

  // R3
  busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (code_q != CODE_ABORTED));

endmodule

// File: rtl/can_txbuf_rdmux.sv
module can_txbuf_rdmux #(
  parameter int NUM_MB = 4,
  parameter int TS_W   = 16,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [NUM_MB-1:0][3:0]    codes,
  input  logic [NUM_MB-1:0][TS_W-1:0] stamps,
  output logic [3:0]                rd_code,
  output logic [TS_W-1:0]           rd_stamp
);

  always_comb begin
    rd_code  = '0;
    rd_stamp = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_code  = codes[i];
        rd_stamp = stamps[i];
      end
    end
  end

endmodule

// File: rtl/can_txbuf_lifecycle.sv
module can_txbuf_lifecycle #(
  parameter int NUM_MB = 4,
  parameter int TS_W   = 16,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_en,
  input  logic              cpu_wr_en,
  input  logic [IDX_W-1:0]  cpu_wr_idx,
  input  logic [3:0]        cpu_wr_code,
  input  logic              cpu_clr_en,
  input  logic [NUM_MB-1:0] cpu_clr_bits,
  input  logic [IDX_W-1:0]  cpu_rd_idx,
  output logic [3:0]        cpu_rd_code,
  output logic [TS_W-1:0]   cpu_rd_stamp,
  input  logic              eng_start,
  input  logic [IDX_W-1:0]  eng_start_idx,
  input  logic              eng_done,
  input  logic [IDX_W-1:0]  eng_done_idx,
  input  logic [TS_W-1:0]   timer_val,
  input  logic [NUM_MB-1:0] irq_mask,
  output logic [NUM_MB-1:0] flags,
  output logic              irq
);

  logic [NUM_MB-1:0]           wr_sel, start_sel, done_sel;
  logic [NUM_MB-1:0][3:0]      codes;
  logic [NUM_MB-1:0][TS_W-1:0] stamps;

  can_txbuf_dec #(.NUM_MB(NUM_MB)) u_dec (
    .wr_en     (cpu_wr_en),
    .wr_idx    (cpu_wr_idx),
    .start     (eng_start),
    .start_idx (eng_start_idx),
    .done      (eng_done),
    .done_idx  (eng_done_idx),
    .wr_sel    (wr_sel),
    .start_sel (start_sel),
    .done_sel  (done_sel)
  );

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    can_txbuf_slot #(.TS_W(TS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_en  (abort_en),
      .wr_i      (wr_sel[g]),
      .wr_code_i (cpu_wr_code),
      .start_i   (start_sel[g]),
      .done_i    (done_sel[g]),
      .clr_i     (cpu_clr_en && cpu_clr_bits[g]),
      .timer_i   (timer_val),
      .code_o    (codes[g]),
      .flag_o    (flags[g]),
      .stamp_o   (stamps[g])
    );
  end

  can_txbuf_rdmux #(.NUM_MB(NUM_MB), .TS_W(TS_W)) u_rdmux (
    .rd_idx   (cpu_rd_idx),
    .codes    (codes),
    .stamps   (stamps),
    .rd_code  (cpu_rd_code),
    .rd_stamp (cpu_rd_stamp)
  );

  assign irq = |(flags & irq_mask);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr_en && !eng_done && !cpu_wr_en) |=> ((flags & $past(cpu_clr_bits)) == '0));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

endmodule

// File: tb/can_txbuf_lifecycle_tb.sv
`timescale 1ns/1ps
module can_txbuf_lifecycle_tb;

  localparam int NUM_MB = 4;
  localparam int TS_W   = 16;
  localparam int IDX_W  = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic abort_en = 0;
  logic cpu_wr_en = 0;
  logic [IDX_W-1:0] cpu_wr_idx = 0;
  logic [3:0] cpu_wr_code = 0;
  logic cpu_clr_en = 0;
  logic [NUM_MB-1:0] cpu_clr_bits = 0;
  logic [IDX_W-1:0] cpu_rd_idx = 0;
  logic [3:0] cpu_rd_code;
  logic [TS_W-1:0] cpu_rd_stamp;
  logic eng_start = 0;
  logic [IDX_W-1:0] eng_start_idx = 0;
  logic eng_done = 0;
  logic [IDX_W-1:0] eng_done_idx = 0;
  logic [TS_W-1:0] timer_val = 0;
  logic [NUM_MB-1:0] irq_mask = '1;
  logic [NUM_MB-1:0] flags;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  can_txbuf_lifecycle #(.NUM_MB(NUM_MB), .TS_W(TS_W)) u_dut (.*);

  typedef struct packed {
    logic        ab;
    logic        wr;
    logic [3:0]  wc;
    logic        st;
    logic        dn;
    logic        cl;
    logic [15:0] ts;
    logic [3:0]  ec;
    logic        ef;
    logic [15:0] es;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0000,4'd2},  // R2 arm
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0000,4'd3},  // R3 start
    '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,16'h0123,4'h8,1'b1,16'h0123,4'd4},  // R4 done
    '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b1,16'h0000,4'h8,1'b0,16'h0123,4'd6},  // R6 clear
    '{1'b1,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0123,4'd2},  // R2
    '{1'b1,1'b1,4'h9,1'b0,1'b0,1'b0,16'h0000,4'h9,1'b1,16'h0123,4'd7},  // R7 abort idle
    '{1'b1,1'b0,4'h0,1'b1,1'b0,1'b0,16'h0000,4'h9,1'b1,16'h0123,4'd7},  // R7 start ignored
    '{1'b1,1'b0,4'h0,1'b0,1'b1,1'b0,16'h0555,4'h9,1'b1,16'h0123,4'd3},  // R3 done ignored
    '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b1,16'h0000,4'h9,1'b0,16'h0123,4'd6},  // R6
    '{1'b1,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0123,4'd2},  // R2 from aborted
    '{1'b1,1'b1,4'h9,1'b1,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0123,4'd8},  // R8 abort with start
    '{1'b1,1'b1,4'h9,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0123,4'd8},  // R8 abort busy
    '{1'b1,1'b0,4'h0,1'b0,1'b1,1'b0,16'h0200,4'h8,1'b1,16'h0200,4'd8},  // R8 completes
    '{1'b1,1'b1,4'hC,1'b0,1'b0,1'b1,16'h0000,4'hC,1'b0,16'h0200,4'd6},  // R6
    '{1'b1,1'b0,4'h0,1'b1,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0200,4'd3},  // R3
    '{1'b1,1'b0,4'h0,1'b0,1'b1,1'b1,16'h0300,4'h8,1'b1,16'h0300,4'd6},  // R6 set wins
    '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b1,16'h0000,4'h8,1'b0,16'h0300,4'd6},  // R6
    '{1'b0,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd2},  // R2
    '{1'b0,1'b1,4'h8,1'b0,1'b0,1'b0,16'h0000,4'h8,1'b0,16'h0300,4'd9},  // R9 idle off
    '{1'b0,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd2},  // R2
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd3},  // R3
    '{1'b0,1'b1,4'h8,1'b0,1'b0,1'b0,16'h0000,4'h8,1'b0,16'h0300,4'd9},  // R9 busy off
    '{1'b0,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'h8,1'b0,16'h0300,4'd11}, // R11 rearm blocked
    '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,16'h0400,4'h8,1'b0,16'h0300,4'd9},  // R9 silent done
    '{1'b0,1'b1,4'hC,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd2},  // R2
    '{1'b0,1'b1,4'h9,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd10}, // R10
    '{1'b1,1'b1,4'h8,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd10}, // R10
    '{1'b1,1'b1,4'h3,1'b0,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd2},  // R2 bad code
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,16'h0000,4'hC,1'b0,16'h0300,4'd3},  // R3
    '{1'b0,1'b1,4'h8,1'b0,1'b1,1'b0,16'h0500,4'h8,1'b1,16'h0500,4'd11}  // R11 done wins
  };

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_wr_en = 0; eng_start = 0; eng_done = 0; cpu_clr_en = 0; cpu_clr_bits = '0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NUM_MB; i++) begin
      cpu_rd_idx = IDX_W'(i);
      #1;
      chk("R1", "code", cpu_rd_code, 4'h8);
      chk("R1", "stamp", cpu_rd_stamp, 0);
    end
    chk("R1", "flags", flags, 0);
    chk("R1", "irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    cpu_rd_idx = 1;
    for (int v = 0; v < NV; v++) begin
      abort_en      = VEC[v].ab;
      cpu_wr_en     = VEC[v].wr;
      cpu_wr_idx    = 1;
      cpu_wr_code   = VEC[v].wc;
      eng_start     = VEC[v].st;
      eng_start_idx = 1;
      eng_done      = VEC[v].dn;
      eng_done_idx  = 1;
      cpu_clr_en    = VEC[v].cl;
      cpu_clr_bits  = 4'b0010;
      timer_val     = VEC[v].ts;
      @(negedge clk);
      idle_inputs();
      #1;
      chk($sformatf("R%0d", VEC[v].rq), $sformatf("vec%0d code", v), cpu_rd_code, VEC[v].ec);
      chk($sformatf("R%0d", VEC[v].rq), $sformatf("vec%0d flag", v), flags[1], VEC[v].ef);
      chk($sformatf("R%0d", VEC[v].rq), $sformatf("vec%0d stamp", v), cpu_rd_stamp, VEC[v].es);
      chk("R5", $sformatf("vec%0d irq", v), irq, VEC[v].ef);
    end

    // R3: other buffers untouched by traffic on buffer 1
    cpu_rd_idx = 0; #1;
    chk("R3", "slot0 code", cpu_rd_code, 4'h8);
    chk("R3", "slot0 flag", flags[0], 0);

    // R5: mask gates the interrupt (flag 1 still set)
    irq_mask = 4'b1101; #1;
    chk("R5", "masked irq", irq, 0);
    irq_mask = 4'b0010; #1;
    chk("R5", "unmasked irq", irq, 1);

    // R6: zero clear bits leave the flag alone
    @(negedge clk);
    cpu_clr_en = 1; cpu_clr_bits = 4'b1101;
    @(negedge clk); idle_inputs(); #1;
    chk("R6", "clear with 0 bit", flags[1], 1);

    // R4 on buffer 3 with a different timer value
    irq_mask = '1; abort_en = 1;
    cpu_wr_en = 1; cpu_wr_idx = 3; cpu_wr_code = 4'hC;
    @(negedge clk); idle_inputs();
    eng_start = 1; eng_start_idx = 3;
    @(negedge clk); idle_inputs();
    eng_done = 1; eng_done_idx = 3; timer_val = 16'hBEEF;
    @(negedge clk); idle_inputs(); #1;
    cpu_rd_idx = 3; #1;
    chk("R4", "slot3 code", cpu_rd_code, 4'h8);
    chk("R4", "slot3 stamp", cpu_rd_stamp, 16'hBEEF);
    chk("R4", "flags", flags, 4'b1010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule